// File: doc/BRIEF.md
# Framed Serial Word Transmitter

This peripheral sits on a processor's word-addressed register bus and turns 16-bit words into a framed serial stream. It always acts as the clock master. It divides the system clock down to a bit clock and drives three lines: the bit clock, a frame-sync pulse that marks the first bit of each word, and serial data. Data is sent most significant bit first and changes on the rising edge of the bit clock, so a receiver samples it on the falling edge.

Software paces the transfer through two status flags. The ready flag comes up a few bits into a word. Clearing it by writing a one tells software it may queue the next word into the single holding stage in front of the shifter. Queued words follow one another with no idle bit between them. The underflow flag reports that the shifter finished a word with nothing waiting behind it. It stays set until software pulses the soft-reset bit, which is the usual way to close a burst.

Top module: `sertx_port`

## Requirements
- R1: After reset the control and parameter registers read 0, the divider reads 2, status reads 0, and the bit-clock, frame-sync and data outputs are low.
- R2: Bus reads are combinational while select is high and write is low. The registers sit at these word addresses: control at 0x800 (bit 0 enables the clock, bit 1 is soft reset, all other bits read 0), parameter at 0x801 (8 bits, read back as written), divider at 0x805 (8 bits, read back as written), status at 0x806 and transmit data at 0x820 (write-only, reads 0). Any other address reads 0.
- R3: While the clock-enable bit is 1 and soft reset is 0, the bit clock period is N system cycles, where N is the divider value and values 0 and 1 count as 2. While it is not running, the bit clock stays low and shifting pauses with the word kept.
- R4: Each word is sent as 16 bits, most significant bit first. Data changes only with a rising bit-clock edge, and frame sync is high for exactly the first bit of each word.
- R5: The transmit register is one holding stage. An idle shifter takes it at the next bit-clock rise, and a busy shifter takes it as the current word ends. When a word is waiting, its first bit follows the previous word's last bit directly, so frame starts are exactly 16 bits apart.
- R6: The ready flag is status bit 4. It is set at the rising edge that starts bit index 3 (the fourth bit) of a word, provided the holding stage is empty. Writing 1 to bit 4 of status clears it, and writing 0 leaves it unchanged.
- R7: The underflow flag is status bit 5. It is set when a word's last bit ends with the holding stage empty. No status write clears it, and it is not raised while a word is queued.
- R8: While control bit 1 is 1, both flags are cleared, the holding and shift contents are discarded and all serial outputs are low. Nothing resumes transmission once the bit is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| ser_clk_o | output | 1 | Bit clock |
| ser_fsync_o | output | 1 | Frame-sync pulse, first bit of each word |
| ser_data_o | output | 1 | Serial data, MSB first |

## Verification
A register write takes effect at the clock edge where it is accepted, and a read returns the new value in the next cycle. After the enable bit is written, the first bit-clock rise comes two system cycles later and carries a word if one is waiting. The ready flag changes at the rise that starts the fourth bit. The bench polls status every cycle and records how many falling bit-clock edges its receiver model has counted inside the current frame when ready first reads 1; that count must be exactly 3. Underflow rises one bit-clock rise after the receiver has taken the last bit, so the bench waits a margin of several bit periods before it reads status. All serial checks rely on a receiver model that samples on falling bit-clock edges, so no check depends on the cycle in which the design updates.

// File: rtl/sertx_pkg.sv
`timescale 1ns/1ps
package sertx_pkg;

    localparam int WORD_W = 16;
    localparam int BUS_AW = 12;

    // Word addresses decoded by software.
    localparam logic [BUS_AW-1:0] RA_CTRL  = 12'h800;
    localparam logic [BUS_AW-1:0] RA_PARAM = 12'h801;
    localparam logic [BUS_AW-1:0] RA_DIV   = 12'h805;
    localparam logic [BUS_AW-1:0] RA_STAT  = 12'h806;
    localparam logic [BUS_AW-1:0] RA_TXD   = 12'h820;

    localparam int ST_RDY_BIT = 4;
    localparam int ST_UND_BIT = 5;

    // Control word: bit 1 soft reset, bit 0 clock enable.
    typedef struct packed {
        logic soft_rst;
        logic clk_en;
    } ctrl_t;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } shift_state_e;

    typedef struct packed {
        logic ready;
        logic underflow;
    } flags_t;

    // Bus side effects handed from the register file to the datapath.
    typedef struct packed {
        logic              load_tx;
        logic              clr_rdy;
        logic [WORD_W-1:0] data;
    } bus_evt_t;

    function automatic logic [WORD_W-1:0] pack_status(input flags_t f);
        logic [WORD_W-1:0] s;
        s = '0;
        s[ST_RDY_BIT] = f.ready;
        s[ST_UND_BIT] = f.underflow;
        return s;
    endfunction

endpackage

// File: rtl/sertx_regs.sv
`timescale 1ns/1ps
module sertx_regs
    import sertx_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int PARAM_W = 8,
    parameter int DIV_RST = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [BUS_AW-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  flags_t              flags,
    output ctrl_t               ctrl_q,
    output logic [PARAM_W-1:0]  param_q,
    output logic [DIV_W-1:0]    div_q,
    output bus_evt_t            evt,
    output logic [WORD_W-1:0]   bus_rdata
);

    localparam int CTRL_W = $bits(ctrl_t);

    logic wr_en;
    logic rd_en;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            param_q <= '0;
            div_q   <= DIV_W'(DIV_RST);
        end else if (wr_en) begin
            case (bus_addr)
                RA_CTRL:  ctrl_q  <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
                RA_PARAM: param_q <= bus_wdata[PARAM_W-1:0];
                RA_DIV:   div_q   <= bus_wdata[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    always_comb begin
        evt.load_tx = wr_en && (bus_addr == RA_TXD);
        evt.clr_rdy = wr_en && (bus_addr == RA_STAT) && bus_wdata[ST_RDY_BIT];
        evt.data    = bus_wdata;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (bus_addr)
                RA_CTRL:  bus_rdata = {{(WORD_W-CTRL_W){1'b0}}, ctrl_q};
                RA_PARAM: bus_rdata = {{(WORD_W-PARAM_W){1'b0}}, param_q};
                RA_DIV:   bus_rdata = {{(WORD_W-DIV_W){1'b0}}, div_q};
                RA_STAT:  bus_rdata = pack_status(flags);
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sertx_bitclk.sv
`timescale 1ns/1ps
module sertx_bitclk #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             rise_evt,
    output logic             sclk
);

    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

    logic [DIV_W-1:0] eff;
    logic [DIV_W-1:0] last;
    logic [DIV_W-1:0] cnt;

    assign eff  = (div < MIN_DIV) ? MIN_DIV : div;
    assign last = eff - 1'b1;

    // Parked at terminal count while stopped, so the first edge after
    // enable is a real rising edge that can carry data.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= last;
        end else if (cnt >= last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign rise_evt = run && (cnt >= last);
    assign sclk     = run && (cnt < (eff >> 1));

endmodule

// File: rtl/sertx_shift.sv
`timescale 1ns/1ps
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int W        = 16,
    parameter int READY_AT = 3,
    localparam int CNT_W   = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             srst,
    input  logic             rise_evt,
    input  bus_evt_t         evt,
    output logic             sdata,
    output logic             fsync,
    output logic             set_rdy,
    output logic             set_und,
    output logic [CNT_W-1:0] bitcnt
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] RDY_PRE  = CNT_W'(READY_AT - 1);

    shift_state_e   state;
    logic [W-1:0]   shreg;
    logic [W-1:0]   hold_q;
    logic           hold_full;
    logic           busy;
    logic           at_end;
    logic           load;

    assign busy   = (state == SH_BUSY);
    assign at_end = busy && (bitcnt == LAST_BIT);
    assign load   = rise_evt && hold_full && (!busy || at_end);

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            state     <= SH_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else begin
            if (evt.load_tx) begin
                hold_q    <= evt.data[W-1:0];
                hold_full <= 1'b1;
            end else if (load) begin
                hold_full <= 1'b0;
            end

            if (load) begin
                shreg  <= hold_q;
                bitcnt <= '0;
                state  <= SH_BUSY;
            end else if (rise_evt && busy) begin
                if (at_end) begin
                    state <= SH_IDLE;
                end else begin
                    shreg  <= {shreg[W-2:0], 1'b0};
                    bitcnt <= bitcnt + 1'b1;
                end
            end
        end
    end

    assign set_rdy = rise_evt && busy && (bitcnt == RDY_PRE) && !hold_full;
    assign set_und = rise_evt && at_end && !hold_full;

    assign sdata = busy && shreg[W-1];
    assign fsync = busy && (bitcnt == '0);

endmodule

// File: rtl/sertx_status.sv
`timescale 1ns/1ps
module sertx_status
    import sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   srst,
    input  logic   set_rdy,
    input  logic   set_und,
    input  logic   clr_rdy,
    output flags_t flags
);

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            flags <= '0;
        end else begin
            if (set_rdy) begin
                flags.ready <= 1'b1;
            end else if (clr_rdy) begin
                flags.ready <= 1'b0;
            end
            if (set_und) begin
                flags.underflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sertx_port.sv
`timescale 1ns/1ps
module sertx_port
    import sertx_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int PARAM_W  = 8,
    parameter int DIV_RST  = 2,
    parameter int READY_AT = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        ser_clk_o,
    output logic        ser_fsync_o,
    output logic        ser_data_o
);

    localparam int CNT_W = $clog2(WORD_W);

    ctrl_t              ctrl_q;
    logic [PARAM_W-1:0] param_q;
    logic [DIV_W-1:0]   div_q;
    bus_evt_t           evt;
    flags_t             flags;
    logic               soft_rst;
    logic               run;
    logic               rise_evt;
    logic               set_rdy;
    logic               set_und;
    logic [CNT_W-1:0]   shift_bitcnt;

    assign soft_rst = ctrl_q.soft_rst;
    assign run      = ctrl_q.clk_en && !ctrl_q.soft_rst;

    sertx_regs #(
        .DIV_W   (DIV_W),
        .PARAM_W (PARAM_W),
        .DIV_RST (DIV_RST)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .flags     (flags),
        .ctrl_q    (ctrl_q),
        .param_q   (param_q),
        .div_q     (div_q),
        .evt       (evt),
        .bus_rdata (bus_rdata)
    );

    sertx_bitclk #(
        .DIV_W (DIV_W)
    ) u_bitclk (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .div      (div_q),
        .rise_evt (rise_evt),
        .sclk     (ser_clk_o)
    );

    sertx_shift #(
        .W        (WORD_W),
        .READY_AT (READY_AT)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .srst     (soft_rst),
        .rise_evt (rise_evt),
        .evt      (evt),
        .sdata    (ser_data_o),
        .fsync    (ser_fsync_o),
        .set_rdy  (set_rdy),
        .set_und  (set_und),
        .bitcnt   (shift_bitcnt)
    );

    sertx_status u_status (
        .clk     (clk),
        .rst     (rst),
        .srst    (soft_rst),
        .set_rdy (set_rdy),
        .set_und (set_und),
        .clr_rdy (evt.clr_rdy),
        .flags   (flags)
    );

endmodule

// File: rtl/sertx_checker.sv
`timescale 1ns/1ps
module sertx_checker #(
    parameter int READY_AT = 3,
    parameter int CNT_W    = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             soft_rst,
    input logic             sclk,
    input logic             fsync,
    input logic             sdata,
    input logic             rdy,
    input logic             und,
    input logic [CNT_W-1:0] bitcnt
);

    logic srst_d;

    always_ff @(posedge clk) begin
        if (rst) srst_d <= 1'b0;
        else     srst_d <= soft_rst;
    end

    // R4: serial data moves only together with a rising bit clock
    a_r4_data_on_rise: assert property (@(posedge clk) disable iff (rst || soft_rst || srst_d)
        !$stable(sdata) |-> $rose(sclk));

    // R4: a frame starts on a rising bit clock
    a_r4_fsync_with_rise: assert property (@(posedge clk) disable iff (rst || soft_rst || srst_d)
        $rose(fsync) |-> $rose(sclk));

    // R6: ready comes up as the configured bit index begins
    a_r6_ready_at_bit: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy) |-> (bitcnt == CNT_W'(READY_AT)));

    // R7: underflow stays set until soft reset
    a_r7_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
        (und && !soft_rst) |=> und);

    // R7: underflow rises only as the line goes idle
    a_r7_underflow_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(und) |-> (!fsync && !sdata));

    // R8: soft reset clears flags and silences the line
    a_r8_softrst_clears: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!rdy && !und && !fsync && !sdata));

endmodule

bind sertx_port sertx_checker #(
    .READY_AT (READY_AT),
    .CNT_W    (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .sclk     (ser_clk_o),
    .fsync    (ser_fsync_o),
    .sdata    (ser_data_o),
    .rdy      (flags.ready),
    .und      (flags.underflow),
    .bitcnt   (shift_bitcnt)
);

// File: tb/tb_sertx_port.sv
`timescale 1ns/1ps
module tb_sertx_port;

    localparam logic [11:0] A_CTRL  = 12'h800;
    localparam logic [11:0] A_PARAM = 12'h801;
    localparam logic [11:0] A_DIV   = 12'h805;
    localparam logic [11:0] A_STAT  = 12'h806;
    localparam logic [11:0] A_TXD   = 12'h820;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ser_clk_o;
    logic        ser_fsync_o;
    logic        ser_data_o;

    always #4 clk = ~clk;

    sertx_port dut (
        .clk         (clk),
        .rst         (rst),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .ser_clk_o   (ser_clk_o),
        .ser_fsync_o (ser_fsync_o),
        .ser_data_o  (ser_data_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Receiver model: samples on falling bit-clock edges.
    logic        mon_prev = 1'b0;
    bit          mon_in = 1'b0;
    int          mon_nbits = 0;
    logic [15:0] mon_sh = '0;
    logic [15:0] rx_word [0:63];
    int          rx_start [0:63];
    int          rx_cnt = 0;
    int          fall_idx = 0;
    int          cur_start = 0;
    int          frames = 0;
    int          abort_req = 0;
    int          abort_seen = 0;

    always @(negedge clk) begin
        if (abort_req != abort_seen) begin
            abort_seen = abort_req;
            mon_in = 1'b0;
        end
        if (mon_prev && !ser_clk_o) begin
            fall_idx++;
            if (ser_fsync_o) begin
                mon_in = 1'b1;
                mon_sh = {15'b0, ser_data_o};
                mon_nbits = 1;
                cur_start = fall_idx;
                frames++;
            end else if (mon_in) begin
                mon_sh = {mon_sh[14:0], ser_data_o};
                mon_nbits++;
            end
            if (mon_in && mon_nbits == 16) begin
                if (rx_cnt < 64) begin
                    rx_word[rx_cnt] = mon_sh;
                    rx_start[rx_cnt] = cur_start;
                end
                rx_cnt++;
                mon_in = 1'b0;
            end
        end
        mon_prev = ser_clk_o;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic soft_reset();
        abort_req++;
        wr(A_CTRL, 16'h0002);
        wr(A_CTRL, 16'h0000);
    endtask

    task automatic wait_rx(input int target, input string req);
        int k = 0;
        while (rx_cnt < target && k < 5000) begin
            @(negedge clk);
            k++;
        end
        check(rx_cnt >= target, req, rx_cnt, target);
    endtask

    task automatic measure_period(output int p);
        logic prev;
        int   k;
        p = 0;
        prev = ser_clk_o;
        k = 0;
        while (k < 100 && !(!prev && ser_clk_o)) begin
            prev = ser_clk_o;
            @(negedge clk);
            k++;
        end
        prev = ser_clk_o;
        k = 0;
        do begin
            prev = ser_clk_o;
            @(negedge clk);
            k++;
        end while (k < 100 && !(!prev && ser_clk_o));
        p = k;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        rd(A_CTRL, v);  check(v == 16'h0000, "R1 ctrl after reset", v, 16'h0000);
        rd(A_PARAM, v); check(v == 16'h0000, "R1 param after reset", v, 16'h0000);
        rd(A_DIV, v);   check(v == 16'h0002, "R1 div after reset", v, 16'h0002);
        rd(A_STAT, v);  check(v == 16'h0000, "R1 status after reset", v, 16'h0000);
        check({ser_clk_o, ser_fsync_o, ser_data_o} == 3'b000, "R1 outputs low",
              {ser_clk_o, ser_fsync_o, ser_data_o}, 0);
    endtask

    task automatic t_regs();
        logic [15:0] v;
        wr(A_PARAM, 16'h004F); rd(A_PARAM, v); check(v == 16'h004F, "R2 param readback", v, 16'h004F);
        wr(A_DIV, 16'h0007);   rd(A_DIV, v);   check(v == 16'h0007, "R2 div readback", v, 16'h0007);
        wr(A_CTRL, 16'hFFFC);  rd(A_CTRL, v);  check(v == 16'h0000, "R2 ctrl upper bits", v, 16'h0000);
        rd(A_TXD, v);   check(v == 16'h0000, "R2 tx reads zero", v, 16'h0000);
        rd(12'h7FF, v); check(v == 16'h0000, "R2 unmapped reads zero", v, 16'h0000);
    endtask

    task automatic t_clkdiv();
        int p;
        int highs;
        wr(A_DIV, 16'h0005); wr(A_CTRL, 16'h0001);
        repeat (20) @(negedge clk);
        measure_period(p); check(p == 5, "R3 period div=5", p, 5);
        wr(A_DIV, 16'h0002);
        repeat (20) @(negedge clk);
        measure_period(p); check(p == 2, "R3 period div=2", p, 2);
        wr(A_DIV, 16'h0000);
        repeat (20) @(negedge clk);
        measure_period(p); check(p == 2, "R3 period div=0 as 2", p, 2);
        wr(A_CTRL, 16'h0000);
        highs = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (ser_clk_o) highs++;
        end
        check(highs == 0, "R3 clock held low when disabled", highs, 0);
    endtask

    task automatic t_single();
        logic [15:0] v;
        int nb;
        int base;
        soft_reset();
        wr(A_DIV, 16'h0002);
        wr(A_CTRL, 16'h0001);
        base = rx_cnt;
        nb = -1;
        wr(A_TXD, 16'hA5C3);
        for (int i = 0; i < 400; i++) begin
            rd(A_STAT, v);
            if (v[4]) begin
                nb = mon_nbits;
                break;
            end
        end
        check(nb == 3, "R6 ready after three bits", nb, 3);
        wait_rx(base + 1, "R4 single word received");
        check(rx_word[base] == 16'hA5C3, "R4 msb-first word", rx_word[base], 16'hA5C3);
        repeat (12) @(negedge clk);
        rd(A_STAT, v); check(v[5] == 1'b1, "R7 underflow after last word", v[5], 1);
        wr(A_STAT, 16'h0000); rd(A_STAT, v);
        check(v[4] == 1'b1, "R6 write 0 keeps ready", v[4], 1);
        wr(A_STAT, 16'h0020); rd(A_STAT, v);
        check(v[5:4] == 2'b11, "R7 status write keeps underflow", v[5:4], 2'b11);
        wr(A_STAT, 16'h0010); rd(A_STAT, v);
        check(v[5:4] == 2'b10, "R6 write 1 clears ready only", v[5:4], 2'b10);
    endtask

    task automatic t_stream();
        logic [15:0] v;
        logic [15:0] w [0:2];
        int base;
        int f0;
        bit got;
        w[0] = 16'h8001; w[1] = 16'h7FFE; w[2] = 16'h3C5A;
        soft_reset();
        wr(A_DIV, 16'h0003);
        wr(A_CTRL, 16'h0001);
        base = rx_cnt;
        f0 = frames;
        for (int i = 0; i < 3; i++) begin
            wr(A_TXD, w[i]);
            if (i < 2) begin
                got = 1'b0;
                for (int k = 0; k < 500 && !got; k++) begin
                    rd(A_STAT, v);
                    got = v[4];
                end
                check(got, "R6 ready seen during stream", got, 1);
                wr(A_STAT, 16'h0010);
            end
        end
        rd(A_STAT, v); check(v[5] == 1'b0, "R7 no underflow while queued", v[5], 0);
        wait_rx(base + 3, "R5 three words received");
        for (int i = 0; i < 3; i++)
            check(rx_word[base+i] == w[i], "R4 stream word", rx_word[base+i], w[i]);
        check(rx_start[base+1] - rx_start[base] == 16, "R5 no gap word0-1",
              rx_start[base+1] - rx_start[base], 16);
        check(rx_start[base+2] - rx_start[base+1] == 16, "R5 no gap word1-2",
              rx_start[base+2] - rx_start[base+1], 16);
        check(frames - f0 == 3, "R4 one frame sync per word", frames - f0, 3);
    endtask

    task automatic t_srst();
        logic [15:0] v;
        int f0;
        int k;
        soft_reset();
        wr(A_DIV, 16'h0004);
        wr(A_CTRL, 16'h0001);
        wr(A_TXD, 16'hFFFF);
        k = 0;
        while (!(mon_in && mon_nbits >= 2) && k < 400) begin
            @(negedge clk);
            k++;
        end
        wr(A_TXD, 16'h5555);
        abort_req++;
        wr(A_CTRL, 16'h0003);
        rd(A_STAT, v); check(v == 16'h0000, "R8 flags cleared", v, 0);
        @(negedge clk);
        check({ser_clk_o, ser_fsync_o, ser_data_o} == 3'b000, "R8 outputs low",
              {ser_clk_o, ser_fsync_o, ser_data_o}, 0);
        f0 = frames;
        wr(A_CTRL, 16'h0001);
        repeat (200) @(negedge clk);
        check(frames == f0, "R8 queued word discarded", frames, f0);
    endtask

    task automatic t_disable();
        int highs;
        int base;
        soft_reset();
        wr(A_DIV, 16'h0002);
        base = rx_cnt;
        wr(A_TXD, 16'h1234);
        highs = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (ser_clk_o) highs++;
        end
        check(highs == 0 && rx_cnt == base, "R3 no shifting while disabled", highs, 0);
        wr(A_CTRL, 16'h0001);
        wait_rx(base + 1, "R5 held word sent after enable");
        check(rx_word[base] == 16'h1234, "R5 held word value", rx_word[base], 16'h1234);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_clkdiv();
        t_single();
        t_stream();
        t_srst();
        t_disable();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule